// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA Channel

This block is one transmit channel of a descriptor-driven DMA engine. Software places descriptors in a small on-chip descriptor RAM and packet bytes in a local buffer RAM. It then writes the address of the first descriptor into the head pointer register. The engine walks the linked list. For every descriptor it owns, it streams the buffer bytes out on a byte-wide valid/ready port. It then writes status back into the descriptor, which returns that descriptor to software.

The engine stops at the end of the list and marks that descriptor end-of-queue. Software can later link more work and restart the engine by rewriting the head pointer. Completions are reported through a pending interrupt request, which software clears by writing the address of the last completed descriptor into the completion pointer register. A teardown command aborts the channel and leaves a fixed marker in the completion pointer. A soft reset clears the channel pointers.

Register byte offsets: 0x00 control (bit 0 enables the channel), 0x04 head pointer, 0x08 completion pointer, 0x0C teardown command, 0x10 soft reset. The descriptor RAM occupies the upper half of the register address space, starting at byte 0x100 by default. A descriptor address is therefore a byte address in that window, 16-byte aligned. A value of zero never names a descriptor.

Top module: `dma_tx_channel`

## Requirements
- R1: After reset, tx_valid, irq and host_err are 0, and the control, head, completion and soft-reset registers read 0.
- R2: A descriptor is four 32-bit words at offsets +0 (next-descriptor address), +4 (buffer byte address), +8 (byte count in bits 15:0) and +12 (mode/status word). The engine sends the byte count's worth of bytes, in address order, starting at the buffer address.
- R3: tx_last is 1 on the final byte of a descriptor if and only if mode bit 30 (end of packet) is set.
- R4: While tx_valid is 1 and tx_ready is 0, tx_valid stays 1 and tx_data holds its value, unless the transfer is aborted.
- R5: The engine follows next-descriptor addresses until it reaches zero. Each write-back clears mode bit 29 (ownership) and sets bit 28 (end of queue) only on the descriptor whose next address is zero. All other bits, including bits 31, 30, 26 and the packet length in bits 10:0, are kept unchanged.
- R6: After end of queue, rewriting the head pointer with a newly linked descriptor restarts the engine.
- R7: A head pointer write starts processing only when control bit 0 is 1 and the value is nonzero. The head pointer reads back the descriptor being processed, and 0 when the engine is idle.
- R8: If a fetched descriptor has bit 29 clear, the engine sends no data, leaves the descriptor unchanged, goes idle and raises host_err. host_err stays set until a soft reset.
- R9: irq is raised after each write-back. It is cleared only by a completion pointer write whose value equals the address of the most recently written-back descriptor.
- R10: Writing the channel number (0 by default) to the teardown register aborts the transfer. The current descriptor gets bit 27 set, bit 29 clear and bit 28 set. The completion pointer becomes 0xFFFFFFFC and irq is raised until that marker is written back. Any other value written to the teardown register is ignored.
- R11: Writing 1 to the soft-reset register aborts the engine and clears the head pointer, completion pointer, irq and host_err. The register reads 1 for RST_CYCLES cycles and 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register/descriptor write strobe |
| reg_addr | input | ADDR_W | Byte address of register or descriptor word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| buf_wr | input | 1 | Buffer RAM write strobe |
| buf_addr | input | BUF_AW | Buffer RAM byte address |
| buf_wdata | input | 8 | Buffer RAM write byte |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of a packet |
| tx_ready | input | 1 | Downstream accepts the byte |
| irq | output | 1 | Completion interrupt request pending |
| host_err | output | 1 | A descriptor without ownership was fetched |

## Verification
The assertions assume that software issues at most one register write per cycle. They also assume that every descriptor address is 16-byte aligned inside the descriptor window, that buffers stay inside the buffer RAM, and that software does not modify a descriptor while the engine owns it. The stimulus keeps to these rules. It writes through a single sequential task, builds every descriptor before it publishes the head pointer, and touches only a descriptor's next word after that descriptor has been returned. tx_ready is driven independently of tx_valid, sometimes from a pseudo-random pattern, so that stalls land on every byte position.

// File: rtl/dma_tx_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the transmit DMA channel.
package dma_tx_pkg;
    // Mode word bit positions decoded by software.
    localparam int BIT_SOP = 31;
    localparam int BIT_EOP = 30;
    localparam int BIT_OWN = 29;
    localparam int BIT_EOQ = 28;
    localparam int BIT_TDC = 27;
    localparam int BIT_CRC = 26;
    localparam logic [31:0] TD_MARKER = 32'hFFFF_FFFC;
    // Register byte offsets.
    localparam logic [4:0] OFS_CTRL  = 5'h00;
    localparam logic [4:0] OFS_HEAD  = 5'h04;
    localparam logic [4:0] OFS_CMPL  = 5'h08;
    localparam logic [4:0] OFS_TDOWN = 5'h0C;
    localparam logic [4:0] OFS_SRST  = 5'h10;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_FETCH,
        ENG_CHECK,
        ENG_STREAM,
        ENG_WBACK,
        ENG_TDOWN
    } eng_state_t;
endpackage

// File: rtl/dma_ram.sv
`timescale 1ns/1ps
// Simple RAM with two asynchronous read ports.
// Port A always writes; port B writes only when TWO_WRITERS is set,
// and a B write wins over an A write in the same cycle.
// Assumes addresses are in range; contents are not reset.
module dma_ram #(
    parameter int WIDTH       = 32,
    parameter int DEPTH       = 64,
    parameter bit TWO_WRITERS = 1'b1,
    parameter int AW          = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             a_we,
    input  logic [AW-1:0]    a_addr,
    input  logic [WIDTH-1:0] a_wdata,
    output logic [WIDTH-1:0] a_rdata,
    input  logic             b_we,
    input  logic [AW-1:0]    b_addr,
    input  logic [WIDTH-1:0] b_wdata,
    output logic [WIDTH-1:0] b_rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    assign a_rdata = mem[a_addr];
    assign b_rdata = mem[b_addr];

    generate
        if (TWO_WRITERS) begin : g_two
            // Storage update, port B has priority.
            always_ff @(posedge clk) begin
                if (b_we)
                    mem[b_addr] <= b_wdata;
                else if (a_we)
                    mem[a_addr] <= a_wdata;
            end
        end else begin : g_one
            logic unused_b;
            assign unused_b = ^{b_we, b_wdata};
            // Storage update from port A only.
            always_ff @(posedge clk) begin
                if (a_we)
                    mem[a_addr] <= a_wdata;
            end
        end
    endgenerate
endmodule

// File: rtl/dma_tx_engine.sv
`timescale 1ns/1ps
// Descriptor walker for one transmit channel.
// It fetches four descriptor words, checks ownership and streams the
// buffer. It then writes the mode word back and follows the next pointer.
// Assumes 16-byte aligned descriptors inside the descriptor window.
// kill aborts at once without write-back; tdown aborts with a
// teardown write-back.
module dma_tx_engine import dma_tx_pkg::*; #(
    parameter int DESC_AW = 6,
    parameter int BUF_AW  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [31:0]        start_addr,
    input  logic               kill,
    input  logic               tdown,
    output logic [DESC_AW-1:0] d_addr,
    input  logic [31:0]        d_rdata,
    output logic               d_we,
    output logic [31:0]        d_wdata,
    output logic [BUF_AW-1:0]  b_addr,
    input  logic [7:0]         b_rdata,
    output logic               tx_valid,
    output logic [7:0]         tx_data,
    output logic               tx_last,
    input  logic               tx_ready,
    output logic               busy,
    output logic [31:0]        cur_ptr,
    output logic               wb_pulse,
    output logic               err_pulse
);
    eng_state_t         state;
    logic [1:0]         word_idx;
    logic [1:0]         word_sel;
    logic [31:0]        nxt;
    logic [BUF_AW-1:0]  bptr;
    logic [15:0]        remain;
    logic               own_q;
    logic               eop_q;

    assign word_sel = (state == ENG_FETCH) ? word_idx : 2'd3;
    assign d_addr   = {cur_ptr[DESC_AW+1:4], word_sel};
    assign b_addr   = bptr;

    // Walk state, descriptor fields and stream position.
    always_ff @(posedge clk) begin
        if (!rst_n || kill) begin
            state    <= ENG_IDLE;
            cur_ptr  <= '0;
            word_idx <= '0;
            nxt      <= '0;
            bptr     <= '0;
            remain   <= '0;
            own_q    <= 1'b0;
            eop_q    <= 1'b0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (start) begin
                        cur_ptr  <= start_addr;
                        word_idx <= '0;
                        state    <= ENG_FETCH;
                    end
                end
                ENG_FETCH: begin
                    case (word_idx)
                        2'd0:    nxt    <= d_rdata;
                        2'd1:    bptr   <= d_rdata[BUF_AW-1:0];
                        2'd2:    remain <= d_rdata[15:0];
                        default: begin
                            own_q <= d_rdata[BIT_OWN];
                            eop_q <= d_rdata[BIT_EOP];
                        end
                    endcase
                    word_idx <= word_idx + 1'b1;
                    if (word_idx == 2'd3)
                        state <= ENG_CHECK;
                end
                ENG_CHECK: begin
                    if (!own_q) begin
                        state   <= ENG_IDLE;
                        cur_ptr <= '0;
                    end else if (remain == '0) begin
                        state <= ENG_WBACK;
                    end else begin
                        state <= ENG_STREAM;
                    end
                end
                ENG_STREAM: begin
                    if (tx_ready) begin
                        bptr   <= bptr + 1'b1;
                        remain <= remain - 1'b1;
                        if (remain == 16'd1)
                            state <= ENG_WBACK;
                    end
                end
                ENG_WBACK: begin
                    if (nxt == '0) begin
                        state   <= ENG_IDLE;
                        cur_ptr <= '0;
                    end else begin
                        cur_ptr  <= nxt;
                        word_idx <= '0;
                        state    <= ENG_FETCH;
                    end
                end
                default: begin
                    state   <= ENG_IDLE;
                    cur_ptr <= '0;
                end
            endcase
            if (tdown && state != ENG_IDLE && state != ENG_TDOWN)
                state <= ENG_TDOWN;
        end
    end

    // Mode word write-back: ownership returned, queue and teardown flags.
    always_comb begin
        d_wdata = d_rdata;
        d_wdata[BIT_OWN] = 1'b0;
        if (state == ENG_TDOWN) begin
            d_wdata[BIT_TDC] = 1'b1;
            d_wdata[BIT_EOQ] = 1'b1;
        end else begin
            d_wdata[BIT_EOQ] = (nxt == '0);
        end
    end

    assign d_we      = (state == ENG_WBACK) || (state == ENG_TDOWN);
    assign tx_valid  = (state == ENG_STREAM);
    assign tx_data   = b_rdata;
    assign tx_last   = (state == ENG_STREAM) && (remain == 16'd1) && eop_q;
    assign busy      = (state != ENG_IDLE);
    assign wb_pulse  = (state == ENG_WBACK);
    assign err_pulse = (state == ENG_CHECK) && !own_q;
endmodule

// File: rtl/dma_tx_channel.sv
`timescale 1ns/1ps
// Transmit DMA channel top: register decode, completion and interrupt
// tracking, soft reset sequencing, descriptor and buffer RAMs, and the
// descriptor walker. Assumes one register write per cycle; the
// descriptor window is the upper half of the register address space.
module dma_tx_channel import dma_tx_pkg::*; #(
    parameter int CHAN_ID    = 0,
    parameter int DESC_WORDS = 64,
    parameter int BUF_BYTES  = 256,
    parameter int RST_CYCLES = 4,
    parameter int DESC_AW    = $clog2(DESC_WORDS),
    parameter int BUF_AW     = $clog2(BUF_BYTES),
    parameter int ADDR_W     = DESC_AW + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              buf_wr,
    input  logic [BUF_AW-1:0] buf_addr,
    input  logic [7:0]        buf_wdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic              irq,
    output logic              host_err
);
    localparam int CNT_W = $clog2(RST_CYCLES + 1);

    logic              in_desc;
    logic              wr_ctrl, wr_head, wr_cmpl, wr_tdown, wr_srst;
    logic              kill, start, tdown, srst_busy;
    logic              enable_q, pend_q, herr_q;
    logic [31:0]       cmpl_q, last_q;
    logic [CNT_W-1:0]  rst_cnt;
    logic [31:0]       sw_desc_rd;
    logic              busy, wb_pulse, err_pulse;
    logic [31:0]       head_ptr;
    logic [DESC_AW-1:0] e_addr;
    logic [31:0]       e_rdata, e_wdata;
    logic              e_we;
    logic [BUF_AW-1:0] eb_addr;
    logic [7:0]        eb_rdata;
    logic [7:0]        unused_buf_rd;

    assign in_desc   = reg_addr[ADDR_W-1];
    assign wr_ctrl   = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));
    assign wr_head   = reg_wr && (reg_addr == ADDR_W'(OFS_HEAD));
    assign wr_cmpl   = reg_wr && (reg_addr == ADDR_W'(OFS_CMPL));
    assign wr_tdown  = reg_wr && (reg_addr == ADDR_W'(OFS_TDOWN));
    assign wr_srst   = reg_wr && (reg_addr == ADDR_W'(OFS_SRST));
    assign srst_busy = (rst_cnt != '0);
    assign kill      = wr_srst && reg_wdata[0];
    assign start     = wr_head && enable_q && (reg_wdata != '0) && !busy && !srst_busy;
    assign tdown     = wr_tdown && (reg_wdata == 32'(CHAN_ID)) && !srst_busy;

    // Control, completion pointer, interrupt and error tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= 1'b0;
            cmpl_q   <= '0;
            last_q   <= '0;
            pend_q   <= 1'b0;
            herr_q   <= 1'b0;
            rst_cnt  <= '0;
        end else if (kill) begin
            rst_cnt <= CNT_W'(RST_CYCLES);
            cmpl_q  <= '0;
            last_q  <= '0;
            pend_q  <= 1'b0;
            herr_q  <= 1'b0;
        end else begin
            if (srst_busy)
                rst_cnt <= rst_cnt - 1'b1;
            if (wr_ctrl)
                enable_q <= reg_wdata[0];
            if (err_pulse)
                herr_q <= 1'b1;
            if (wr_cmpl)
                cmpl_q <= reg_wdata;
            if (tdown) begin
                cmpl_q <= TD_MARKER;
                last_q <= TD_MARKER;
                pend_q <= 1'b1;
            end else if (wb_pulse) begin
                last_q <= head_ptr;
                pend_q <= 1'b1;
            end else if (wr_cmpl && reg_wdata == last_q) begin
                pend_q <= 1'b0;
            end
        end
    end

    // Read-back multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (in_desc) begin
            reg_rdata = sw_desc_rd;
        end else begin
            case (reg_addr)
                ADDR_W'(OFS_CTRL): reg_rdata = {31'd0, enable_q};
                ADDR_W'(OFS_HEAD): reg_rdata = head_ptr;
                ADDR_W'(OFS_CMPL): reg_rdata = cmpl_q;
                ADDR_W'(OFS_SRST): reg_rdata = {31'd0, srst_busy};
                default:           reg_rdata = '0;
            endcase
        end
    end

    assign irq      = pend_q;
    assign host_err = herr_q;

    dma_ram #(.WIDTH(32), .DEPTH(DESC_WORDS), .TWO_WRITERS(1'b1)) u_desc_ram (
        .clk     (clk),
        .a_we    (reg_wr && in_desc),
        .a_addr  (reg_addr[ADDR_W-2:2]),
        .a_wdata (reg_wdata),
        .a_rdata (sw_desc_rd),
        .b_we    (e_we),
        .b_addr  (e_addr),
        .b_wdata (e_wdata),
        .b_rdata (e_rdata)
    );

    dma_ram #(.WIDTH(8), .DEPTH(BUF_BYTES), .TWO_WRITERS(1'b0)) u_buf_ram (
        .clk     (clk),
        .a_we    (buf_wr),
        .a_addr  (buf_addr),
        .a_wdata (buf_wdata),
        .a_rdata (unused_buf_rd),
        .b_we    (1'b0),
        .b_addr  (eb_addr),
        .b_wdata (8'd0),
        .b_rdata (eb_rdata)
    );

    dma_tx_engine #(.DESC_AW(DESC_AW), .BUF_AW(BUF_AW)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (reg_wdata),
        .kill       (kill),
        .tdown      (tdown),
        .d_addr     (e_addr),
        .d_rdata    (e_rdata),
        .d_we       (e_we),
        .d_wdata    (e_wdata),
        .b_addr     (eb_addr),
        .b_rdata    (eb_rdata),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_last    (tx_last),
        .tx_ready   (tx_ready),
        .busy       (busy),
        .cur_ptr    (head_ptr),
        .wb_pulse   (wb_pulse),
        .err_pulse  (err_pulse)
    );
endmodule

// File: rtl/dma_tx_channel_chk.sv
`timescale 1ns/1ps
// Protocol checker for dma_tx_channel, attached by bind.
module dma_tx_channel_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [7:0]  tx_data,
    input logic        irq,
    input logic        host_err,
    input logic        kill,
    input logic        tdown,
    input logic        wb_pulse,
    input logic [31:0] head_ptr,
    input logic [31:0] cmpl_q
);
    // R4
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !tdown && !kill) |=> (tx_valid && $stable(tx_data)));

    // R9
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(wb_pulse || tdown));

    // R8
    herr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_err) |-> $past(kill));

    // R11
    srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (head_ptr == 32'd0 && cmpl_q == 32'd0 && !irq && !tx_valid));

    // R10
    td_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tdown |=> (cmpl_q == 32'hFFFF_FFFC && irq));
endmodule

bind dma_tx_channel dma_tx_channel_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .irq      (irq),
    .host_err (host_err),
    .kill     (kill),
    .tdown    (tdown),
    .wb_pulse (wb_pulse),
    .head_ptr (head_ptr),
    .cmpl_q   (cmpl_q)
);

// File: tb/dma_tx_channel_bench.sv
`timescale 1ns/1ps
module dma_tx_channel_bench;
    localparam int AW = 9;
    localparam logic [31:0] SOP = 32'h8000_0000, EOP = 32'h4000_0000,
                            OWN = 32'h2000_0000, EOQ = 32'h1000_0000,
                            TDC = 32'h0800_0000;
    localparam logic [AW-1:0] A_CTRL = 9'h00, A_HEAD = 9'h04, A_CMPL = 9'h08,
                              A_TD = 9'h0C, A_SRST = 9'h10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic buf_wr = 1'b0;
    logic [7:0] buf_addr = '0, buf_wdata = '0;
    logic tx_valid, tx_last, tx_ready = 1'b1, irq, host_err;
    logic [7:0] tx_data;

    int total = 0, failed = 0;
    int ready_mode = 0;
    logic [7:0] lfsr = 8'h5A;
    logic [8:0] exp_q[$];

    always #2 clk = ~clk;

    dma_tx_channel u_dma_tx_channel (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_wr(buf_wr),
        .buf_addr(buf_addr), .buf_wdata(buf_wdata), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
        .irq(irq), .host_err(host_err)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic mkdesc(input logic [31:0] da, input logic [31:0] nxt, input logic [31:0] ba,
                          input logic [31:0] len, input logic [31:0] mode);
        wr(da[AW-1:0], nxt);
        wr(da[AW-1:0] + 9'd4, ba);
        wr(da[AW-1:0] + 9'd8, len);
        wr(da[AW-1:0] + 9'd12, mode);
    endtask

    // Driver: fills the buffer and pushes expected bytes to the scoreboard.
    task automatic load_pkt(input int ba, input int len, input bit eop);
        for (int i = 0; i < len; i++) begin
            logic [7:0] b;
            b = 8'((ba * 7 + i * 13 + 5) & 8'hFF);
            @(negedge clk); buf_wr = 1'b1; buf_addr = 8'(ba + i); buf_wdata = b;
            @(negedge clk); buf_wr = 1'b0;
            exp_q.push_back({eop && (i == len - 1), b});
        end
    endtask

    task automatic wait_done(input string tag);
        logic [31:0] h;
        bit done = 1'b0;
        for (int i = 0; i < 2000 && !done; i++) begin
            rd(A_HEAD, h);
            if (h == 0 && exp_q.size() == 0) done = 1'b1;
        end
        check(done, tag, 32'(exp_q.size()), 32'd0);
    endtask

    task automatic chk_reg(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
        logic [31:0] v;
        rd(a, v);
        check(v === e, tag, v, e);
    endtask

    // tx_ready pattern, changed just after each rising edge.
    always @(posedge clk) begin
        #1;
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        tx_ready <= (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? lfsr[0] : 1'b0;
    end

    // Monitor: pops and compares every accepted byte (R2, R3).
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            total++;
            if (exp_q.size() == 0) begin
                failed++;
                $display("FAIL R2 unexpected byte actual=%h expected=none", tx_data);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                if ({tx_last, tx_data} !== e) begin
                    failed++;
                    $display("FAIL R2/R3 byte actual=%h expected=%h", {tx_last, tx_data}, e);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        failed++; total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!tx_valid && !irq && !host_err, "R1 outputs", {29'd0, tx_valid, irq, host_err}, 32'd0);
        chk_reg(A_CTRL, 0, "R1 ctrl");
        chk_reg(A_HEAD, 0, "R1 head");
        chk_reg(A_CMPL, 0, "R1 cmpl");
        chk_reg(A_SRST, 0, "R1 srst");
        wr(A_CTRL, 1);

        // R2 R3 R5 R9 single descriptor
        load_pkt(8'h00, 5, 1'b1);
        mkdesc(32'h100, 0, 32'h00, 5, SOP | EOP | OWN | 5);
        wr(A_HEAD, 32'h100);
        wait_done("R2 single packet");
        check(irq, "R9 irq after writeback", {31'd0, irq}, 1);
        chk_reg(9'h10C, SOP | EOP | EOQ | 5, "R5 mode single");
        chk_reg(A_HEAD, 0, "R7 head idle");
        wr(A_CMPL, 32'h110);
        check(irq, "R9 wrong ack keeps irq", {31'd0, irq}, 1);
        wr(A_CMPL, 32'h100);
        check(!irq, "R9 matching ack clears irq", {31'd0, irq}, 0);

        // R4 R5 chain under backpressure
        ready_mode = 1;
        load_pkt(8'h10, 3, 1'b0);
        load_pkt(8'h20, 1, 1'b0);
        load_pkt(8'h30, 4, 1'b1);
        mkdesc(32'h110, 32'h120, 32'h10, 3, SOP | OWN | 3);
        mkdesc(32'h120, 32'h130, 32'h20, 1, OWN | 1);
        mkdesc(32'h130, 0, 32'h30, 4, EOP | OWN | 4);
        wr(A_HEAD, 32'h110);
        wait_done("R4 chain");
        chk_reg(9'h11C, SOP | 3, "R5 first of chain");
        chk_reg(9'h12C, 32'd1, "R5 middle of chain");
        chk_reg(9'h13C, EOP | EOQ | 4, "R5 end of chain");
        wr(A_CMPL, 32'h110);
        check(irq, "R9 early ack keeps irq", {31'd0, irq}, 1);
        wr(A_CMPL, 32'h130);
        check(!irq, "R9 last ack clears irq", {31'd0, irq}, 0);

        // R6 restart after end of queue
        load_pkt(8'h40, 2, 1'b1);
        mkdesc(32'h140, 0, 32'h40, 2, SOP | EOP | OWN | 2);
        wr(9'h130, 32'h140);
        wr(A_HEAD, 32'h140);
        wait_done("R6 restart");
        chk_reg(9'h14C, SOP | EOP | EOQ | 2, "R6 restarted descriptor");
        wr(A_CMPL, 32'h140);
        ready_mode = 0;

        // R7 disabled channel ignores head write
        wr(A_CTRL, 0);
        mkdesc(32'h150, 0, 32'h50, 3, SOP | EOP | OWN | 3);
        wr(A_HEAD, 32'h150);
        repeat (30) @(negedge clk);
        chk_reg(A_HEAD, 0, "R7 head while disabled");
        chk_reg(9'h15C, SOP | EOP | OWN | 3, "R7 descriptor untouched");
        wr(A_CTRL, 1);

        // R8 descriptor without ownership
        mkdesc(32'h160, 0, 32'h60, 3, SOP | EOP | 3);
        wr(A_HEAD, 32'h160);
        repeat (20) @(negedge clk);
        check(host_err, "R8 host_err", {31'd0, host_err}, 1);
        check(!irq, "R8 no completion", {31'd0, irq}, 0);
        chk_reg(A_HEAD, 0, "R8 idle");
        chk_reg(9'h16C, SOP | EOP | 3, "R8 descriptor unchanged");

        // R10 teardown while stalled
        ready_mode = 2;
        repeat (3) @(negedge clk);
        mkdesc(32'h170, 0, 32'h70, 8, SOP | EOP | OWN | 8);
        wr(A_HEAD, 32'h170);
        repeat (10) @(negedge clk);
        check(tx_valid, "R10 streaming before teardown", {31'd0, tx_valid}, 1);
        wr(A_TD, 1);
        repeat (3) @(negedge clk);
        check(tx_valid, "R10 other channel ignored", {31'd0, tx_valid}, 1);
        chk_reg(A_CMPL, 32'h140, "R10 cmpl unchanged by other channel");
        wr(A_TD, 0);
        repeat (3) @(negedge clk);
        check(!tx_valid, "R10 aborted", {31'd0, tx_valid}, 0);
        chk_reg(A_CMPL, 32'hFFFF_FFFC, "R10 marker");
        chk_reg(A_HEAD, 0, "R10 head cleared");
        chk_reg(9'h17C, SOP | EOP | EOQ | TDC | 8, "R10 teardown status");
        check(irq, "R10 irq", {31'd0, irq}, 1);
        wr(A_CMPL, 32'hFFFF_FFFC);
        check(!irq, "R10 marker ack", {31'd0, irq}, 0);

        // R11 soft reset while busy
        wr(A_CMPL, 32'h1234);
        mkdesc(32'h180, 0, 32'h80, 4, SOP | EOP | OWN | 4);
        wr(A_HEAD, 32'h180);
        repeat (5) @(negedge clk);
        wr(A_SRST, 1);
        chk_reg(A_SRST, 1, "R11 busy readback");
        repeat (10) @(negedge clk);
        chk_reg(A_SRST, 0, "R11 done readback");
        chk_reg(A_CMPL, 0, "R11 cmpl cleared");
        chk_reg(A_HEAD, 0, "R11 head cleared");
        check(!host_err && !irq && !tx_valid, "R11 flags cleared",
              {29'd0, host_err, irq, tx_valid}, 0);

        // R2 engine works again after soft reset
        ready_mode = 0;
        repeat (3) @(negedge clk);
        load_pkt(8'h90, 6, 1'b1);
        mkdesc(32'h190, 0, 32'h90, 6, SOP | EOP | OWN | 6);
        wr(A_HEAD, 32'h190);
        wait_done("R2 after soft reset");
        check(exp_q.size() == 0, "R2 scoreboard drained", 32'(exp_q.size()), 0);

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule